// File: doc/BRIEF.md
# GPIO Bank Controller

The block controls a bank of general-purpose pins whose count is a multiple of 32. Software reaches it through a plain 32-bit read/write bus. Each pin has a number of features:

- a direction bit
- an output value that changes only through a write-one-to-set word and a write-one-to-clear word
- enables for rising-edge and falling-edge detection
- a sticky edge-status bit
- a 2-bit alternate-function selector

The sampled level of every pin can be read back at any time. A single interrupt line is the OR of every edge-status bit.

The register map is arranged by feature. Each feature occupies a run of NGPIO/32 consecutive words, with pin `p` at bit `p%32` of the feature's word `p/32`. The alternate-function selectors come last and are packed 16 pins per word, so that feature spans twice as many words. Pin inputs are synchronised through two flops before they are used for readback or edge detection.

A bus access takes one cycle. A write takes effect at the clock edge that samples it. Read data appears on `rdata_o` in the cycle after the request and holds until the next read.

Top module: `gpio_bank`

## Requirements
- R1: The feature groups are indexed 0 to 7 in this order: level, direction, set, clear, rising enable, falling enable, edge status, alternate function. Word `w` of group `g` is at byte address `(g*NGPIO/32 + w)*4`. Groups 0 to 6 have NGPIO/32 words each, and group 7 has NGPIO/16 words.
- R2: A read of a level word returns the two-flop-synchronised pin inputs. Writes to level words change nothing.
- R3: Each 1 bit written to a set word drives the matching bit of `gpio_o` high. Each 1 bit written to a clear word drives it low. Zero bits leave the output unchanged, and reads of set and clear words return 0.
- R4: The direction words are read/write and drive `gpio_oe_o`. A 1 means output and a 0 means input.
- R5: An edge-status bit becomes 1 when the synchronised pin rises while its rising enable is 1, or falls while its falling enable is 1. The rising and falling enable words are read/write.
- R6: Writing 1 to an edge-status bit clears it and writing 0 has no effect. If a clear and a qualifying edge on that pin land in the same cycle, the bit stays set.
- R7: `irq_o` is high exactly when at least one edge-status bit in any word is set. It stays high until every status bit has been cleared.
- R8: Each pin has a 2-bit alternate-function field. Pin `p` uses bits `(p%16)*2+1:(p%16)*2` of alternate-function word `p/16`. The field is read/write and appears on `af_o[2p+1:2p]`; the value 0 means plain GPIO.
- R9: After reset, every register is zero. This includes outputs, directions, edge enables, edge status and alternate-function fields, and it leaves `irq_o` low.
- R10: A read at a word beyond the last alternate-function word returns 0. A write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| gpio_i | input | NGPIO | Pin inputs (asynchronous) |
| gpio_o | output | NGPIO | Pin output values |
| gpio_oe_o | output | NGPIO | Pin output enables |
| af_o | output | 2*NGPIO | Alternate-function selectors, 2 bits per pin |
| irq_o | output | 1 | Combined edge interrupt |

## Verification
The one real collision is a software write-one-to-clear of an edge-status bit landing in the same clock as a new qualifying edge on that pin. The bench provokes it by toggling a pin input on a falling clock edge, counting the two synchroniser stages, and presenting the status-clear write so that it is sampled at the exact edge where the detector fires. It judges the result by reading the status word and `irq_o` afterwards, expecting the bit still set. A second, plain clear then shows the bit can fall, which proves the first clear really overlapped the edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    GRP_LEVEL = 3'd0,
    GRP_DIR   = 3'd1,
    GRP_SET   = 3'd2,
    GRP_CLR   = 3'd3,
    GRP_RISE  = 3'd4,
    GRP_FALL  = 3'd5,
    GRP_STAT  = 3'd6,
    GRP_ALTF  = 3'd7
  } grp_e;
  localparam int unsigned NUM_GRP = 8;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NREG = 2,
  parameter int unsigned WW   = 10,
  parameter int unsigned SW   = 2
) (
  input  logic [WW-1:0] word_i,
  output logic          hit_o,
  output grp_e          grp_o,
  output logic [SW-1:0] sub_o
);
  always_comb begin
    hit_o = 1'b0;
    grp_o = GRP_LEVEL;
    sub_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      int lo;
      int span;
      lo   = g * NREG;
      span = (g == NUM_GRP - 1) ? 2 * NREG : NREG;
      if (int'(word_i) >= lo && int'(word_i) < lo + span) begin
        hit_o = 1'b1;
        grp_o = grp_e'(g);
        sub_o = SW'(int'(word_i) - lo);
      end
    end
  end
endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] lvl_d, stat_q, qual;

  assign qual = (lvl_i & ~lvl_d & rise_en_i) | (~lvl_i & lvl_d & fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_d  <= '0;
      stat_q <= '0;
    end else begin
      lvl_d  <= lvl_i;
      // a fresh edge overrides a same-cycle clear
      stat_q <= (stat_q & ~clr_i) | qual;
    end
  end

  assign stat_o = stat_q;

  p_edge_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual != '0) |=> ((stat_o & $past(qual)) == $past(qual)));

  p_clear_only_by_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o != '0) |=> ((($past(stat_o) & ~stat_o) & ~$past(clr_i)) == '0));

  p_set_needs_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == '0) |=> ((stat_o == '0) || ($past(qual) != '0)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NGPIO = 64,
  parameter int unsigned AW    = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NGPIO-1:0]     gpio_i,
  output logic [NGPIO-1:0]     gpio_o,
  output logic [NGPIO-1:0]     gpio_oe_o,
  output logic [2*NGPIO-1:0]   af_o,
  output logic                 irq_o
);
  localparam int unsigned NREG = NGPIO / 32;
  localparam int unsigned NAFW = 2 * NREG;
  localparam int unsigned WW   = AW - 2;
  localparam int unsigned SW   = (NAFW > 1) ? $clog2(NAFW) : 1;

  logic              hit;
  grp_e              grp;
  logic [SW-1:0]     sub;
  logic              wr;
  logic [NGPIO-1:0]  lvl, dir_q, out_q, ren_q, fen_q, stat, clr_vec;
  logic [2*NGPIO-1:0] af_q;
  logic [31:0]       rd_word, rdata_q;

  gpio_bank_sync #(.W(NGPIO)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (lvl)
  );

  gpio_bank_decode #(.NREG(NREG), .WW(WW), .SW(SW)) u_dec (
    .word_i(addr_i[AW-1:2]),
    .hit_o (hit),
    .grp_o (grp),
    .sub_o (sub)
  );

  assign wr = req_i && we_i && hit;

  for (genvar w = 0; w < NREG; w++) begin : g_word
    logic sel;
    assign sel = wr && (sub == SW'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dir_q[w*32 +: 32] <= '0;
        out_q[w*32 +: 32] <= '0;
        ren_q[w*32 +: 32] <= '0;
        fen_q[w*32 +: 32] <= '0;
      end else if (sel) begin
        unique case (grp)
          GRP_DIR:  dir_q[w*32 +: 32] <= wdata_i;
          GRP_SET:  out_q[w*32 +: 32] <= out_q[w*32 +: 32] | wdata_i;
          GRP_CLR:  out_q[w*32 +: 32] <= out_q[w*32 +: 32] & ~wdata_i;
          GRP_RISE: ren_q[w*32 +: 32] <= wdata_i;
          GRP_FALL: fen_q[w*32 +: 32] <= wdata_i;
          default: ;
        endcase
      end
    end

    assign clr_vec[w*32 +: 32] = (sel && grp == GRP_STAT) ? wdata_i : '0;
  end

  for (genvar w = 0; w < NAFW; w++) begin : g_afw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) af_q[w*32 +: 32] <= '0;
      else if (wr && grp == GRP_ALTF && sub == SW'(w)) af_q[w*32 +: 32] <= wdata_i;
    end
  end

  gpio_bank_edge #(.W(NGPIO)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl),
    .rise_en_i(ren_q),
    .fall_en_i(fen_q),
    .clr_i    (clr_vec),
    .stat_o   (stat)
  );

  always_comb begin
    rd_word = '0;
    if (hit) begin
      unique case (grp)
        GRP_LEVEL: rd_word = lvl[32*int'(sub) +: 32];
        GRP_DIR:   rd_word = dir_q[32*int'(sub) +: 32];
        GRP_RISE:  rd_word = ren_q[32*int'(sub) +: 32];
        GRP_FALL:  rd_word = fen_q[32*int'(sub) +: 32];
        GRP_STAT:  rd_word = stat[32*int'(sub) +: 32];
        GRP_ALTF:  rd_word = af_q[32*int'(sub) +: 32];
        default:   rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_word;
  end

  assign rdata_o   = rdata_q;
  assign gpio_o    = out_q;
  assign gpio_oe_o = dir_q;
  assign af_o      = af_q;
  assign irq_o     = |stat;

  p_out_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (grp == GRP_SET || grp == GRP_CLR)) |=> $stable(gpio_o));

  p_setclr_read_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && hit && (grp == GRP_SET || grp == GRP_CLR)) |=> (rdata_o == '0));

  p_oe_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && grp == GRP_DIR) |=> $stable(gpio_oe_o));

  p_oor_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !hit) |=> (rdata_o == '0));

  p_af_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && grp == GRP_ALTF) |=> $stable(af_o));
endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int NG = 64;
  localparam int NR = NG / 32;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NG-1:0] gin = '0, gout, goe;
  logic [2*NG-1:0] af;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank #(.NGPIO(NG), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .gpio_i(gin), .gpio_o(gout),
    .gpio_oe_o(goe), .af_o(af), .irq_o(irq)
  );

  function automatic int adr(int g, int w);
    return (g * NR + w) * 4;
  endfunction

  task automatic check(string req_tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NG-1:0] out_m, dir_m, in_m;
    logic [1:0] af_m [NG];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9", {gout}, '0);
    check("R9", {goe}, '0);
    check("R9", {63'd0, irq}, '0);
    check("R9", af[63:0], '0);
    check("R9", af[127:64], '0);
    for (int g = 1; g < 8; g++)
      for (int w = 0; w < NR; w++) begin
        rd(adr(g, w), d);
        check("R9", {32'd0, d}, '0);
      end

    // R4 direction read/write and oe
    dir_m = 64'hA5A5_0F0F_1234_8001;
    wr(adr(1, 0), dir_m[31:0]);
    wr(adr(1, 1), dir_m[63:32]);
    check("R4", goe, dir_m);
    rd(adr(1, 1), d);
    check("R4 R1", {32'd0, d}, {32'd0, dir_m[63:32]});

    // R3 set/clear sweep per pin
    out_m = '0;
    for (int p = 0; p < NG; p++) begin
      wr(adr(2, p / 32), 32'd1 << (p % 32));
      out_m[p] = 1'b1;
      check("R3", gout, out_m);
    end
    for (int p = 0; p < NG; p += 3) begin
      wr(adr(3, p / 32), 32'd1 << (p % 32));
      out_m[p] = 1'b0;
      check("R3", gout, out_m);
    end
    wr(adr(2, 0), 32'd0);
    wr(adr(3, 1), 32'd0);
    check("R3 zero bits", gout, out_m);
    wr(adr(3, 0), 32'hFFFF_0000);
    out_m[31:16] = '0;
    check("R3", gout, out_m);
    rd(adr(2, 0), d);
    check("R3 read set", {32'd0, d}, '0);
    rd(adr(3, 1), d);
    check("R3 read clr", {32'd0, d}, '0);
    check("R4 untouched", goe, dir_m);

    // R2 level readback under patterns
    for (int k = 0; k < 4; k++) begin
      in_m = {32'hDEAD_0000 ^ (32'h1111_1111 * k), 32'h0F0F_00FF << k};
      gin = in_m;
      settle();
      rd(adr(0, 0), d);
      check("R2", {32'd0, d}, {32'd0, in_m[31:0]});
      rd(adr(0, 1), d);
      check("R2", {32'd0, d}, {32'd0, in_m[63:32]});
    end
    wr(adr(0, 0), ~in_m[31:0]);
    rd(adr(0, 0), d);
    check("R2 write ignored", {32'd0, d}, {32'd0, in_m[31:0]});
    gin = '0;
    settle();

    // R5 rising on word0 low half, falling on word1 high half
    wr(adr(4, 0), 32'h0000_FFFF);
    wr(adr(5, 1), 32'hFFFF_0000);
    rd(adr(4, 0), d);
    check("R5 rise en", {32'd0, d}, 64'h0000_FFFF);
    check("R5 no edge yet", {63'd0, irq}, '0);
    gin = {32'hFFFF_FFFF, 32'h0000_00F0};
    settle();
    rd(adr(6, 0), d);
    check("R5 rise", {32'd0, d}, 64'h0000_00F0);
    rd(adr(6, 1), d);
    check("R5 no fall yet", {32'd0, d}, '0);
    gin = {32'h0000_FFFF, 32'h0000_00F0};
    settle();
    rd(adr(6, 1), d);
    check("R5 fall", {32'd0, d}, 64'hFFFF_0000);
    check("R7 irq set", {63'd0, irq}, 64'd1);

    // R6/R7 W1C, irq stays until all words clear
    wr(adr(6, 0), 32'h0000_0030);
    rd(adr(6, 0), d);
    check("R6 w1c", {32'd0, d}, 64'h0000_00C0);
    wr(adr(6, 0), 32'hFFFF_FFFF);
    check("R7 irq held by word1", {63'd0, irq}, 64'd1);
    wr(adr(6, 1), 32'h0000_0000);
    rd(adr(6, 1), d);
    check("R6 zero write", {32'd0, d}, 64'hFFFF_0000);
    wr(adr(6, 1), 32'hFFFF_0000);
    check("R7 irq cleared", {63'd0, irq}, '0);

    // R6 simultaneous edge and clear on pin 0
    gin = '0;
    settle();
    gin[0] = 1'b1;
    settle();
    rd(adr(6, 0), d);
    check("R6 setup", {32'd0, d}, 64'd1);
    gin[0] = 1'b0;
    settle();
    @(negedge clk);
    gin[0] = 1'b1;
    @(negedge clk);
    wr(adr(6, 0), 32'h0000_0001);
    rd(adr(6, 0), d);
    check("R6 edge wins", {32'd0, d}, 64'd1);
    check("R7 irq", {63'd0, irq}, 64'd1);
    wr(adr(6, 0), 32'h0000_0001);
    rd(adr(6, 0), d);
    check("R6 plain clear", {32'd0, d}, '0);
    check("R7 irq low", {63'd0, irq}, '0);

    // R8 alternate-function sweeps
    for (int pat = 0; pat < 2; pat++) begin
      for (int p = 0; p < NG; p++) af_m[p] = (pat == 0) ? 2'((p * 3 + 1) % 4) : 2'(3 - (p % 4));
      for (int w = 0; w < 2 * NR; w++) begin
        logic [31:0] v;
        v = '0;
        for (int j = 0; j < 16; j++) v[j*2 +: 2] = af_m[w*16 + j];
        wr(adr(7, w), v);
      end
      for (int p = 0; p < NG; p++) check("R8 af_o", {62'd0, af[2*p +: 2]}, {62'd0, af_m[p]});
      for (int p = 0; p < NG; p += 13) begin
        rd(adr(7, p / 16), d);
        check("R8 R1 field", {62'd0, d[(p%16)*2 +: 2]}, {62'd0, af_m[p]});
      end
    end

    // R10 out of range
    wr(adr(7, 2 * NR), 32'hFFFF_FFFF);
    wr(4092, 32'hFFFF_FFFF);
    rd(adr(7, 2 * NR), d);
    check("R10 read", {32'd0, d}, '0);
    rd(4092, d);
    check("R10 read", {32'd0, d}, '0);
    check("R10 out", gout, out_m);
    check("R10 oe", goe, dir_m);
    check("R10 irq", {63'd0, irq}, '0);
    rd(adr(7, 2 * NR - 1), d);
    for (int j = 0; j < 16; j++)
      check("R10 af", {62'd0, d[j*2 +: 2]}, {62'd0, af_m[(2*NR-1)*16 + j]});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule